// File: doc/BRIEF.md
# Coprocessor Idle Clock Controller

This block decides which clocks of a coprocessor subsystem run. It holds two small control registers: a clock-enable register with one bit per peripheral clock, and an idle-permission register with one bit per peripheral clock plus one bit for the shared subdomain. A cleared enable bit stops a peripheral clock at once. A set permission bit stops that clock only while the core clock is off. When the timer runs as a watchdog, its reference clock is always kept running, whatever the registers hold.

A state machine handles the power-down sequence. It starts when the core's idle strobe arrives while the bus bridge reports host-only access. In `ST_RUN` all domain clocks run. `ST_MASK_IRQ` raises the core-idle status and the interrupt-mask request while the core clock still runs. `ST_SYNC` stops the core clock and waits `SYNC_CYCLES` cycles so that the interrupt handler can synchronize. `ST_CORE_OFF` then stops the handler clock. `ST_SUB_OFF` also stops the shared subdomain clock, but only while the host clock is off and the subdomain permission bit is set. If either condition goes away, the machine returns to `ST_CORE_OFF`.

An unmasked wake event brings the clocks back in reverse order. From `ST_SUB_OFF` the path is `ST_WAKE_SUB` (subdomain back on), then `ST_WAKE_CORE` (core back on), then `ST_WAKE_IH` (handler back on, status and mask cleared), then `ST_RUN`. From `ST_CORE_OFF` the path enters at `ST_WAKE_CORE`. Each clock enable passes through a latch that is transparent only while the clock is low, so a gated clock never gets a runt pulse.

Top module: `cop_idle_clkctl`

## Requirements
- R1: While `wdt_mode` is 1, `pclk_en[WDT_IDX]` (bit 0 by default) is 1, whatever the register contents and the controller state.
- R2: A clock whose enable-register bit is 0 has its `pclk_en` bit at 0 from the cycle after the write, whether the core clock is on or off (except the clock kept on by R1).
- R3: A clock whose enable bit is 1 and whose permission bit is 1 is gated exactly while `core_clk_en` is 0. A clock with permission 0 follows only its enable bit.
- R4: The idle strobe is accepted only in `ST_RUN` with `bridge_host_only` = 1. One cycle after it is accepted, `core_idle` is 1 and `core_clk_en` is still 1. In the next cycle `core_clk_en` is 0.
- R5: `irq_mask_req` is 1 from the cycle in which `core_idle` rises until the handler clock is restored, and whenever `core_clk_en` is 0.
- R6: After the core clock stops, `ih_clk_en` stays 1 for exactly `SYNC_CYCLES` cycles (default 2) and then goes to 0.
- R7: `sub_clk_en` goes to 0 only with core and handler clocks off, `host_clk_off` = 1 and permission bit `NUM_PCLK` = 1. It returns to 1 in the cycle after either condition is removed.
- R8: Register writes take effect only while `bridge_host_only` = 0. `reg_sel` = 0 writes `reg_wdata[NUM_PCLK-1:0]` to the enable register, and `reg_sel` = 1 writes all of `reg_wdata` to the permission register. Writes made while `bridge_host_only` = 1 are ignored.
- R9: On wake the clocks return in the order subdomain, core, handler, one step per cycle. `core_idle` and `irq_mask_req` clear in the same cycle that `ih_clk_en` returns, which is one cycle after `core_clk_en` returns.
- R10: During and right after reset, all clock enables are 1, `core_idle` and `irq_mask_req` are 0, the enable register is all ones and the permission register is all zeros.
- R11: A wake is taken only in `ST_CORE_OFF` or `ST_SUB_OFF`, and only when `wake_evt & wake_en` is nonzero. Masked events leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the permission register |
| reg_wdata | input | NUM_PCLK+1 | Write data; the top bit is the subdomain permission |
| bridge_host_only | input | 1 | 1 when the bus bridge is in host-only access mode |
| idle_insn | input | 1 | Strobe from the core when it executes its idle instruction |
| host_clk_off | input | 1 | The host processor clock is disabled |
| wdt_mode | input | 1 | The timer is configured as a watchdog |
| wake_evt | input | NUM_WAKE | Wake event lines |
| wake_en | input | NUM_WAKE | Per-line wake enable |
| core_clk_en | output | 1 | Glitch-free core clock enable |
| ih_clk_en | output | 1 | Glitch-free interrupt-handler clock enable |
| sub_clk_en | output | 1 | Glitch-free shared subdomain clock enable |
| pclk_en | output | NUM_PCLK | Glitch-free peripheral clock enables |
| core_idle | output | 1 | Core-idle status |
| irq_mask_req | output | 1 | Request to the interrupt handler to block interrupts to the core |

## Verification
The hardest situation to reach is a subdomain that keeps dropping in and out of idle while the core stays asleep. The host clock has to toggle while the controller sits in `ST_CORE_OFF`, and a wake has to arrive in `ST_SUB_OFF` rather than `ST_CORE_OFF`, so that the full three-step restore runs. Before that can happen, the registers must be programmed in shared mode and the bridge flag must then be switched to host-only before the idle strobe. The bench walks this path directly and toggles `host_clk_off` twice before an enabled wake. It then runs a long pseudo-random phase with sparse strobes and writes, where a per-cycle reference model catches any order or timing drift.

// File: rtl/icc_pkg.sv
package icc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_MASK_IRQ,
        ST_SYNC,
        ST_CORE_OFF,
        ST_SUB_OFF,
        ST_WAKE_SUB,
        ST_WAKE_CORE,
        ST_WAKE_IH
    } icc_state_e;

    typedef struct packed {
        logic core_on;
        logic ih_on;
        logic sub_on;
        logic idle;
        logic mask;
    } icc_dom_t;

endpackage

// File: rtl/icc_gate_latch.sv
module icc_gate_latch (
    input  logic clk,
    input  logic en_d,
    output logic en_q
);
    // Transparent only while the clock is low, so the enable never
    // changes while the gated clock is high.
    always_latch begin
        if (!clk) en_q <= en_d;
    end
endmodule

// File: rtl/icc_reg_bank.sv
module icc_reg_bank #(
    parameter int NUM_PCLK = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                sel,
    input  logic [NUM_PCLK:0]   wdata,
    input  logic                host_only,
    output logic [NUM_PCLK-1:0] en_q,
    output logic [NUM_PCLK:0]   perm_q
);
    logic wr_ok;

    // Programming is only legal while the bridge is in shared mode.
    assign wr_ok = wr && !host_only;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '1;
            perm_q <= '0;
        end else if (wr_ok) begin
            if (sel) perm_q <= wdata;
            else     en_q   <= wdata[NUM_PCLK-1:0];
        end
    end
endmodule

// File: rtl/icc_periph_gate.sv
module icc_periph_gate #(
    parameter int NUM_PCLK = 4,
    parameter int WDT_IDX  = 0
) (
    input  logic [NUM_PCLK-1:0] en_q,
    input  logic [NUM_PCLK-1:0] perm_q,
    input  logic                core_gated,
    input  logic                wdt_mode,
    output logic [NUM_PCLK-1:0] pclk_req
);
    for (genvar i = 0; i < NUM_PCLK; i++) begin : g_clk
        logic deferred_off;
        assign deferred_off = perm_q[i] && core_gated;
        if (i == WDT_IDX) begin : g_wdt
            assign pclk_req[i] = wdt_mode || (en_q[i] && !deferred_off);
        end else begin : g_plain
            assign pclk_req[i] = en_q[i] && !deferred_off;
        end
    end
endmodule

// File: rtl/icc_ctl_fsm.sv
module icc_ctl_fsm
    import icc_pkg::*;
#(
    parameter int SYNC_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     idle_req,
    input  logic     host_only,
    input  logic     host_clk_off,
    input  logic     sub_perm,
    input  logic     wake,
    output icc_dom_t dom
);
    localparam int CW = $clog2(SYNC_CYCLES + 1);
    localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_CYCLES - 1);

    icc_state_e     state, state_nx;
    logic [CW-1:0]  sync_cnt;
    logic           sub_ok;

    assign sub_ok = host_clk_off && sub_perm;

    // State register and synchronisation counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            sync_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SYNC && state_nx == ST_SYNC) sync_cnt <= sync_cnt + 1'b1;
            else                                         sync_cnt <= '0;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:       if (idle_req && host_only) state_nx = ST_MASK_IRQ;
            ST_MASK_IRQ:  state_nx = ST_SYNC;
            ST_SYNC:      if (sync_cnt == SYNC_LAST) state_nx = ST_CORE_OFF;
            ST_CORE_OFF: begin
                if (wake)        state_nx = ST_WAKE_CORE;
                else if (sub_ok) state_nx = ST_SUB_OFF;
            end
            ST_SUB_OFF: begin
                if (wake)         state_nx = ST_WAKE_SUB;
                else if (!sub_ok) state_nx = ST_CORE_OFF;
            end
            ST_WAKE_SUB:  state_nx = ST_WAKE_CORE;
            ST_WAKE_CORE: state_nx = ST_WAKE_IH;
            ST_WAKE_IH:   state_nx = ST_RUN;
        endcase
    end

    // Outputs per state
    always_comb begin
        dom = '{core_on: 1'b1, ih_on: 1'b1, sub_on: 1'b1, idle: 1'b0, mask: 1'b0};
        unique case (state)
            ST_RUN, ST_WAKE_IH: ;
            ST_MASK_IRQ:  dom = '{core_on: 1'b1, ih_on: 1'b1, sub_on: 1'b1, idle: 1'b1, mask: 1'b1};
            ST_SYNC:      dom = '{core_on: 1'b0, ih_on: 1'b1, sub_on: 1'b1, idle: 1'b1, mask: 1'b1};
            ST_CORE_OFF,
            ST_WAKE_SUB:  dom = '{core_on: 1'b0, ih_on: 1'b0, sub_on: 1'b1, idle: 1'b1, mask: 1'b1};
            ST_SUB_OFF:   dom = '{core_on: 1'b0, ih_on: 1'b0, sub_on: 1'b0, idle: 1'b1, mask: 1'b1};
            ST_WAKE_CORE: dom = '{core_on: 1'b1, ih_on: 1'b0, sub_on: 1'b1, idle: 1'b1, mask: 1'b1};
        endcase
    end
endmodule

// File: rtl/cop_idle_clkctl.sv
module cop_idle_clkctl
    import icc_pkg::*;
#(
    parameter int NUM_PCLK    = 4,
    parameter int NUM_WAKE    = 2,
    parameter int SYNC_CYCLES = 2,
    parameter int WDT_IDX     = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [NUM_PCLK:0]   reg_wdata,
    input  logic                bridge_host_only,
    input  logic                idle_insn,
    input  logic                host_clk_off,
    input  logic                wdt_mode,
    input  logic [NUM_WAKE-1:0] wake_evt,
    input  logic [NUM_WAKE-1:0] wake_en,
    output logic                core_clk_en,
    output logic                ih_clk_en,
    output logic                sub_clk_en,
    output logic [NUM_PCLK-1:0] pclk_en,
    output logic                core_idle,
    output logic                irq_mask_req
);
    logic [NUM_PCLK-1:0] en_q;
    logic [NUM_PCLK:0]   perm_q;
    logic [NUM_PCLK-1:0] pclk_req;
    icc_dom_t            dom;
    logic                wake;

    assign wake = |(wake_evt & wake_en);

    icc_reg_bank #(.NUM_PCLK(NUM_PCLK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .host_only(bridge_host_only), .en_q(en_q), .perm_q(perm_q)
    );

    icc_ctl_fsm #(.SYNC_CYCLES(SYNC_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_insn), .host_only(bridge_host_only),
        .host_clk_off(host_clk_off), .sub_perm(perm_q[NUM_PCLK]), .wake(wake), .dom(dom)
    );

    icc_periph_gate #(.NUM_PCLK(NUM_PCLK), .WDT_IDX(WDT_IDX)) u_pgate (
        .en_q(en_q), .perm_q(perm_q[NUM_PCLK-1:0]), .core_gated(!dom.core_on),
        .wdt_mode(wdt_mode), .pclk_req(pclk_req)
    );

    icc_gate_latch u_core_gl (.clk(clk), .en_d(dom.core_on), .en_q(core_clk_en));
    icc_gate_latch u_ih_gl   (.clk(clk), .en_d(dom.ih_on),   .en_q(ih_clk_en));
    icc_gate_latch u_sub_gl  (.clk(clk), .en_d(dom.sub_on),  .en_q(sub_clk_en));

    for (genvar i = 0; i < NUM_PCLK; i++) begin : g_pgl
        icc_gate_latch u_gl (.clk(clk), .en_d(pclk_req[i]), .en_q(pclk_en[i]));
    end

    assign core_idle    = dom.idle;
    assign irq_mask_req = dom.mask;
endmodule

// File: rtl/icc_checks.sv
module icc_checks #(
    parameter int NUM_PCLK    = 4,
    parameter int SYNC_CYCLES = 2,
    parameter int WDT_IDX     = 0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wdt_mode,
    input logic                host_clk_off,
    input logic                core_clk_en,
    input logic                ih_clk_en,
    input logic                sub_clk_en,
    input logic [NUM_PCLK-1:0] pclk_en,
    input logic                core_idle,
    input logic                irq_mask_req,
    input logic [NUM_PCLK-1:0] en_q
);
    logic [NUM_PCLK-1:0] keep;
    logic [31:0]         sync_seen;

    always_comb begin
        keep          = '0;
        keep[WDT_IDX] = wdt_mode;
    end

    // Consecutive cycles with the core stopped and the handler still clocked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        sync_seen <= '0;
        else if (!core_clk_en && ih_clk_en) sync_seen <= sync_seen + 1;
        else                               sync_seen <= '0;
    end

    a_r1_wdt_clock_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_mode |-> pclk_en[WDT_IDX]);

    a_r2_disabled_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_en & ~en_q & ~keep) == '0);

    a_r3_enabled_run_with_core: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> ((en_q & ~pclk_en) == '0));

    a_r4_core_stops_after_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_idle) |-> core_clk_en ##1 !core_clk_en);

    a_r5_mask_covers_core_off: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> irq_mask_req);

    a_r6_sync_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ih_clk_en) |-> (sync_seen == 32'(SYNC_CYCLES)));

    a_r7_sub_after_core_ih: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_clk_en |-> (!core_clk_en && !ih_clk_en));

    a_r7_sub_needs_host_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sub_clk_en) |-> $past(host_clk_off));

    a_r9_core_before_ih: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (sub_clk_en && !ih_clk_en));

    a_r9_mask_drop_after_core: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_mask_req) |-> ($past(core_clk_en) && ih_clk_en && !core_idle));
endmodule

bind cop_idle_clkctl icc_checks #(
    .NUM_PCLK(NUM_PCLK), .SYNC_CYCLES(SYNC_CYCLES), .WDT_IDX(WDT_IDX)
) u_icc_checks (
    .clk(clk), .rst_n(rst_n), .wdt_mode(wdt_mode), .host_clk_off(host_clk_off),
    .core_clk_en(core_clk_en), .ih_clk_en(ih_clk_en), .sub_clk_en(sub_clk_en),
    .pclk_en(pclk_en), .core_idle(core_idle), .irq_mask_req(irq_mask_req), .en_q(en_q)
);

// File: tb/cop_idle_clkctl_test.sv
`timescale 1ns/1ps
module cop_idle_clkctl_test;
    localparam int NP = 4;
    localparam int NW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr, reg_sel, bridge_host_only, idle_insn, host_clk_off, wdt_mode;
    logic [NP:0]   reg_wdata;
    logic [NW-1:0] wake_evt, wake_en;
    logic          core_clk_en, ih_clk_en, sub_clk_en, core_idle, irq_mask_req;
    logic [NP-1:0] pclk_en;

    int nvec  = 0;
    int nfail = 0;

    // Reference model state: 0 run, 1 masking, 2 sync, 3 core off,
    // 4 sub off, 5 wake sub, 6 wake core, 7 wake handler
    int            m_st;
    int            m_sync_left;
    logic [NP-1:0] m_en;
    logic [NP:0]   m_perm;

    always #2 clk = ~clk;

    cop_idle_clkctl #(.NUM_PCLK(NP), .NUM_WAKE(NW), .SYNC_CYCLES(2), .WDT_IDX(0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .bridge_host_only(bridge_host_only), .idle_insn(idle_insn), .host_clk_off(host_clk_off),
        .wdt_mode(wdt_mode), .wake_evt(wake_evt), .wake_en(wake_en),
        .core_clk_en(core_clk_en), .ih_clk_en(ih_clk_en), .sub_clk_en(sub_clk_en),
        .pclk_en(pclk_en), .core_idle(core_idle), .irq_mask_req(irq_mask_req)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit mdl_core_on();
        return (m_st == 0 || m_st == 1 || m_st == 6 || m_st == 7);
    endfunction

    function automatic logic [NP-1:0] mdl_pclk();
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) begin
            r[i] = m_en[i] && !(m_perm[i] && !mdl_core_on());
        end
        if (wdt_mode) r[0] = 1'b1;
        return r;
    endfunction

    // Move to the low phase and compare every output against the model.
    task automatic settle();
        bit idle_exp;
        #2.5;
        idle_exp = (m_st >= 1 && m_st <= 6);
        check("R4", "core_clk_en", 32'(core_clk_en), 32'(mdl_core_on()));
        check("R6", "ih_clk_en", 32'(ih_clk_en), 32'(m_st <= 2 || m_st == 7));
        check("R7", "sub_clk_en", 32'(sub_clk_en), 32'(m_st != 4));
        check("R2", "pclk_en", 32'(pclk_en), 32'(mdl_pclk()));
        check("R9", "core_idle", 32'(core_idle), 32'(idle_exp));
        check("R5", "irq_mask_req", 32'(irq_mask_req), 32'(idle_exp));
    endtask

    // Clock edge: update the model with the inputs the design samples.
    task automatic advance();
        bit wk;
        @(posedge clk);
        if (!rst_n) begin
            m_st = 0; m_en = '1; m_perm = '0; m_sync_left = 0;
        end else begin
            wk = |(wake_evt & wake_en);
            case (m_st)
                0: if (idle_insn && bridge_host_only) m_st = 1;
                1: begin m_st = 2; m_sync_left = 2; end
                2: begin m_sync_left--; if (m_sync_left == 0) m_st = 3; end
                3: if (wk) m_st = 6; else if (host_clk_off && m_perm[NP]) m_st = 4;
                4: if (wk) m_st = 5; else if (!(host_clk_off && m_perm[NP])) m_st = 3;
                5: m_st = 6;
                6: m_st = 7;
                default: m_st = 0;
            endcase
            if (reg_wr && !bridge_host_only) begin
                if (reg_sel) m_perm = reg_wdata;
                else         m_en   = reg_wdata[NP-1:0];
            end
        end
        #1;
    endtask

    task automatic cyc();
        settle();
        advance();
    endtask

    task automatic write_reg(input logic sel, input logic [NP:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0; reg_wr = 0; reg_sel = 0; reg_wdata = '0; bridge_host_only = 0;
        idle_insn = 0; host_clk_off = 0; wdt_mode = 0; wake_evt = '0; wake_en = '0;
        m_st = 0; m_en = '1; m_perm = '0; m_sync_left = 0;
        #3;
        // R10: reset state
        repeat (3) begin
            settle();
            check("R10", "reset clocks", 32'({core_clk_en, ih_clk_en, sub_clk_en, pclk_en}), 32'h7F);
            check("R10", "reset status", 32'({core_idle, irq_mask_req}), 32'h0);
            advance();
        end
        rst_n = 1'b1;
        cyc();

        // R2: clearing enable bits gates at once, core running
        write_reg(1'b0, 5'b0_1010);
        settle(); check("R2", "pclk after enable write", 32'(pclk_en), 32'h0A); advance();

        // R8: write in host-only mode is ignored
        bridge_host_only = 1'b1;
        write_reg(1'b0, 5'b0_0000);
        settle(); check("R8", "pclk after blocked write", 32'(pclk_en), 32'h0A); advance();

        // R4: idle strobe ignored in shared mode
        bridge_host_only = 1'b0;
        idle_insn = 1'b1; cyc(); idle_insn = 1'b0;
        settle(); check("R4", "idle in shared mode", 32'(core_idle), 32'h0); advance();

        write_reg(1'b0, 5'b0_1111);
        write_reg(1'b1, 5'b1_0110);

        // Power down with the watchdog running
        wdt_mode = 1'b1; bridge_host_only = 1'b1;
        idle_insn = 1'b1; cyc(); idle_insn = 1'b0;
        settle();
        check("R4", "status before core stop", 32'({core_idle, core_clk_en}), 32'h3);
        advance();
        settle();
        check("R6", "handler on during sync", 32'({core_clk_en, ih_clk_en}), 32'h1);
        check("R3", "permitted clocks gated", 32'(pclk_en), 32'h09);
        advance();
        cyc();
        settle(); check("R6", "handler off after sync", 32'(ih_clk_en), 32'h0); advance();

        // R11: masked wake ignored
        wake_evt = 2'b01; wake_en = 2'b10;
        repeat (3) cyc();
        settle(); check("R11", "masked wake", 32'({core_clk_en, core_idle}), 32'h1); advance();
        wake_evt = '0;

        // R7: subdomain follows host clock
        host_clk_off = 1'b1; cyc();
        settle(); check("R7", "sub off with host off", 32'(sub_clk_en), 32'h0); advance();
        host_clk_off = 1'b0; cyc();
        settle(); check("R7", "sub back with host on", 32'(sub_clk_en), 32'h1); advance();
        host_clk_off = 1'b1; repeat (2) cyc();

        // R9: wake from subdomain idle
        wake_evt = 2'b10; cyc(); wake_evt = '0;
        settle(); check("R9", "sub first", 32'({sub_clk_en, core_clk_en}), 32'h2); advance();
        settle(); check("R9", "core second", 32'({core_clk_en, ih_clk_en, irq_mask_req}), 32'h5); advance();
        settle(); check("R9", "handler and status", 32'({ih_clk_en, irq_mask_req, core_idle}), 32'h4); advance();
        host_clk_off = 1'b0;
        cyc();

        // R1: watchdog clock survives a zero enable
        bridge_host_only = 1'b0;
        write_reg(1'b0, 5'b0_0000);
        settle(); check("R1", "watchdog clock kept", 32'(pclk_en), 32'h01); advance();
        wdt_mode = 1'b0;
        settle(); check("R1", "watchdog released", 32'(pclk_en), 32'h00); advance();

        // R7: no subdomain idle without its permission bit
        write_reg(1'b0, 5'b0_1111);
        write_reg(1'b1, 5'b0_1111);
        bridge_host_only = 1'b1; host_clk_off = 1'b1;
        idle_insn = 1'b1; cyc(); idle_insn = 1'b0;
        repeat (6) cyc();
        settle(); check("R7", "sub kept without permission", 32'(sub_clk_en), 32'h1);
        check("R3", "all permitted clocks off", 32'(pclk_en), 32'h0); advance();
        wake_evt = 2'b11; wake_en = 2'b01; cyc(); wake_evt = '0;
        repeat (4) cyc();
        settle(); check("R11", "wake from core off", 32'({core_clk_en, core_idle}), 32'h2); advance();

        // Pseudo-random phase
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            reg_wr           = (lfsr[3:0] == 4'h5);
            reg_sel          = lfsr[4];
            reg_wdata        = lfsr[9:5];
            bridge_host_only = (lfsr[11:10] != 2'b00);
            idle_insn        = (lfsr[14:12] == 3'b101);
            if (lfsr[2:0] == 3'b011) host_clk_off = ~host_clk_off;
            if (lfsr[8:6] == 3'b111) wdt_mode = ~wdt_mode;
            wake_evt         = (lfsr[15:12] == 4'h9) ? lfsr[1:0] : 2'b00;
            wake_en          = lfsr[7:6];
            cyc();
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule